// File: doc/BRIEF.md
# Floppy Controller Data Rate Selector

This block holds the 2-bit data rate code of a floppy disk controller. Host software can set the code through either of two register addresses. One is a configuration control alias that carries only the rate field. The other is a data rate select register whose upper bits hold unrelated settings. Both aliases feed a single shared rate field, so the most recent write to either of them decides the active rate.

The active code drives two external rate pins. It also selects a divider ratio that rescales the bit-cell clocks of the data separator and the microengine. The ratio is computed as a base clock frequency divided by the selected bit rate. A one-cycle pulse marks every write that actually changes the rate, so the clock generator can resynchronise. The six upper bits of a data rate select write are latched and exposed for downstream decoders.

Top module: `fdc_rate_select`

## Requirements
- R1: After a synchronous reset the rate pins read 00, the divider select reads 6, the change pulse is low and the latched upper bits read 0.
- R2: A write strobe with address 0x3F7 loads data bits 1:0 into the rate code, visible on the rate pins from the cycle after the strobe.
- R3: A write strobe with address 0x004 loads data bits 1:0 into the same rate code, with the same one-cycle latency.
- R4: The rate code always equals the bits 1:0 of the most recent write to either address, whichever alias it went to.
- R5: Writes to any other address, and cycles without a strobe, leave the rate code, divider select and latched bits unchanged.
- R6: The divider select is 3000 kHz divided by the rate: code 00 (500 kb/s) gives 6, 01 (300 kb/s) gives 10, 10 (250 kb/s) gives 12, 11 (1 Mb/s) gives 3. It changes in the same cycle as the rate pins.
- R7: The change pulse is high for exactly the one cycle after a strobe whose rate field differs from the active code. It stays low after a write of the same code.
- R8: A write to 0x004 latches data bits 7:2 onto the upper-bits output on the following cycle. Writes to 0x3F7 never alter that output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 10 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_wr | input | 1 | Write strobe, one cycle per write |
| rate_pins | output | 2 | Active rate code to the external pins |
| clk_div_sel | output | 4 | Bit-cell clock divider ratio |
| rate_chg | output | 1 | One-cycle pulse after each rate change |
| dsr_upper | output | 6 | Latched bits 7:2 of the data rate select register |

## Verification
A wrong internal rate state shows on the rate pins one cycle after the offending write and stays wrong until the next rate write. The divider select shows the error in that same cycle, because it must always match the pins. A missed or extra change pulse is visible only in the single cycle after a write, so the bench compares every output on every clock against a behavioural model. Interleaved writes to both aliases, repeated codes and decoy addresses expose errors in alias priority and in decoding.

// File: rtl/fdc_rate_pkg.sv
package fdc_rate_pkg;

    typedef enum logic [1:0] {
        RATE_500K = 2'b00,
        RATE_300K = 2'b01,
        RATE_250K = 2'b10,
        RATE_1M   = 2'b11
    } rate_code_e;

    typedef struct packed {
        logic ccr_hit;
        logic dsr_hit;
    } alias_hit_t;

    typedef struct packed {
        alias_hit_t hit;
        rate_code_e rate;
        logic [5:0] upper;
    } host_req_t;

    localparam rate_code_e RESET_RATE = RATE_500K;

    function automatic int rate_kbps(rate_code_e code);
        case (code)
            RATE_500K: return 500;
            RATE_300K: return 300;
            RATE_250K: return 250;
            default:   return 1000;
        endcase
    endfunction

    function automatic int div_for(int base_khz, rate_code_e code);
        return base_khz / rate_kbps(code);
    endfunction

endpackage

// File: rtl/fdc_rate_decode.sv
module fdc_rate_decode
    import fdc_rate_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int CCR_ADDR = 'h3F7,
    parameter int DSR_ADDR = 'h004
) (
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    input  logic              host_wr,
    output host_req_t         req
);
    localparam logic [ADDR_W-1:0] CCR_A = ADDR_W'(CCR_ADDR);
    localparam logic [ADDR_W-1:0] DSR_A = ADDR_W'(DSR_ADDR);

    always_comb begin
        req.hit.ccr_hit = host_wr && (host_addr == CCR_A);
        req.hit.dsr_hit = host_wr && (host_addr == DSR_A);
        req.rate        = rate_code_e'(host_wdata[1:0]);
        req.upper       = host_wdata[7:2];
    end

    // R5: at most one alias can be selected by a single address
    always_comb begin
        a_one_alias_r5: assert ($onehot0({req.hit.ccr_hit, req.hit.dsr_hit}));
    end
endmodule

// File: rtl/fdc_rate_hold.sv
module fdc_rate_hold
    import fdc_rate_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  rate_code_e new_rate,
    output rate_code_e rate_q,
    output logic       chg_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rate_q <= RESET_RATE;
            chg_q  <= 1'b0;
        end else begin
            chg_q <= load && (new_rate != rate_q);
            if (load) rate_q <= new_rate;
        end
    end

    p_last_write_wins_r4: assert property (@(posedge clk) disable iff (rst)
        load |=> (rate_q == $past(new_rate)));
    p_hold_idle_r5: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(rate_q));
    p_pulse_means_change_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(chg_q) |-> (rate_q != $past(rate_q)));
    p_pulse_single_r7: assert property (@(posedge clk) disable iff (rst)
        (chg_q && !$past(load)) |-> 1'b0);
endmodule

// File: rtl/fdc_rate_divmap.sv
module fdc_rate_divmap
    import fdc_rate_pkg::*;
#(
    parameter int BASE_KHZ = 3000,
    parameter int DIV_W    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  rate_code_e       new_rate,
    output logic [DIV_W-1:0] div_q
);
    localparam logic [DIV_W-1:0] RESET_DIV = DIV_W'(div_for(BASE_KHZ, RESET_RATE));

    always_ff @(posedge clk) begin
        if (rst)       div_q <= RESET_DIV;
        else if (load) div_q <= DIV_W'(div_for(BASE_KHZ, new_rate));
    end

    p_div_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(div_q));
    p_div_nonzero_r6: assert property (@(posedge clk) disable iff (rst)
        div_q != '0);
endmodule

// File: rtl/fdc_rate_extreg.sv
module fdc_rate_extreg #(
    parameter int EXT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [EXT_W-1:0] d,
    output logic [EXT_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end

    p_ext_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q));
    p_ext_load_r8: assert property (@(posedge clk) disable iff (rst)
        load |=> (q == $past(d)));
endmodule

// File: rtl/fdc_rate_select.sv
module fdc_rate_select
    import fdc_rate_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int CCR_ADDR = 'h3F7,
    parameter int DSR_ADDR = 'h004,
    parameter int BASE_KHZ = 3000,
    localparam int DIV_W   = $clog2(BASE_KHZ / 250 + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    input  logic              host_wr,
    output logic [1:0]        rate_pins,
    output logic [DIV_W-1:0]  clk_div_sel,
    output logic              rate_chg,
    output logic [5:0]        dsr_upper
);
    host_req_t  req;
    rate_code_e rate_q;
    logic       any_hit;

    fdc_rate_decode #(.ADDR_W(ADDR_W), .CCR_ADDR(CCR_ADDR), .DSR_ADDR(DSR_ADDR)) u_dec (
        .host_addr (host_addr),
        .host_wdata(host_wdata),
        .host_wr   (host_wr),
        .req       (req)
    );

    assign any_hit = req.hit.ccr_hit | req.hit.dsr_hit;

    fdc_rate_hold u_hold (
        .clk     (clk),
        .rst     (rst),
        .load    (any_hit),
        .new_rate(req.rate),
        .rate_q  (rate_q),
        .chg_q   (rate_chg)
    );

    fdc_rate_divmap #(.BASE_KHZ(BASE_KHZ), .DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .load    (any_hit),
        .new_rate(req.rate),
        .div_q   (clk_div_sel)
    );

    fdc_rate_extreg #(.EXT_W(6)) u_ext (
        .clk (clk),
        .rst (rst),
        .load(req.hit.dsr_hit),
        .d   (req.upper),
        .q   (dsr_upper)
    );

    assign rate_pins = rate_q;

    p_div_tracks_pins_r6: assert property (@(posedge clk) disable iff (rst)
        clk_div_sel == DIV_W'(div_for(BASE_KHZ, rate_code_e'(rate_pins))));
    p_ccr_keeps_upper_r8: assert property (@(posedge clk) disable iff (rst)
        req.hit.ccr_hit |=> $stable(dsr_upper));
    p_ccr_loads_r2: assert property (@(posedge clk) disable iff (rst)
        req.hit.ccr_hit |=> (rate_pins == $past(host_wdata[1:0])));
    p_dsr_loads_r3: assert property (@(posedge clk) disable iff (rst)
        req.hit.dsr_hit |=> (rate_pins == $past(host_wdata[1:0])));
endmodule

// File: tb/fdc_rate_select_tb.sv
module fdc_rate_select_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic       host_wr = 1'b0;
    logic [1:0] rate_pins;
    logic [3:0] clk_div_sel;
    logic       rate_chg;
    logic [5:0] dsr_upper;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference model state
    int m_rate = 0;
    int m_chg  = 0;
    int m_ext  = 0;

    always #2 clk = ~clk;

    fdc_rate_select dut_i (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_wr(host_wr), .rate_pins(rate_pins), .clk_div_sel(clk_div_sel),
        .rate_chg(rate_chg), .dsr_upper(dsr_upper)
    );

    function automatic int exp_div(int r);
        case (r)
            0: return 6;
            1: return 10;
            2: return 12;
            default: return 3;
        endcase
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural model, updated at the edge from inputs set half a cycle earlier
    always @(posedge clk) begin
        if (rst) begin
            m_rate = 0; m_chg = 0; m_ext = 0;
        end else begin
            m_chg = 0;
            if (host_wr && (host_addr == 10'h3F7 || host_addr == 10'h004)) begin
                if (int'(host_wdata[1:0]) != m_rate) m_chg = 1;
                m_rate = int'(host_wdata[1:0]);
                if (host_addr == 10'h004) m_ext = int'(host_wdata[7:2]);
            end
        end
    end

    // every-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R4 rate", int'(rate_pins), m_rate);
            chk("R6 div", int'(clk_div_sel), exp_div(m_rate));
            chk("R7 pulse", int'(rate_chg), m_chg);
            chk("R8 upper", int'(dsr_upper), m_ext);
        end
    end

    task automatic wr(logic [9:0] a, logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; host_addr = '0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state, sampled before any write
        chk("R1 pins", int'(rate_pins), 0);
        chk("R1 div", int'(clk_div_sel), 6);
        chk("R1 pulse", int'(rate_chg), 0);
        chk("R1 upper", int'(dsr_upper), 0);

        // R2 configuration alias: pins follow one cycle after the strobe
        wr(10'h3F7, 8'hFE);  // rate 10, upper bits must stay 0
        chk("R2 pins", int'(rate_pins), 2);
        chk("R6 div 250k", int'(clk_div_sel), 12);
        chk("R7 pulse", int'(rate_chg), 1);
        chk("R8 ccr no upper", int'(dsr_upper), 0);
        idle(1);
        chk("R7 pulse one cycle", int'(rate_chg), 0);

        // R3 data rate select alias
        wr(10'h004, 8'b1011_0111);
        chk("R3 pins", int'(rate_pins), 3);
        chk("R6 div 1M", int'(clk_div_sel), 3);
        chk("R8 upper", int'(dsr_upper), 6'b101101);

        // R7 same code again: no pulse
        wr(10'h3F7, 8'h03);
        chk("R7 no pulse same", int'(rate_chg), 0);

        // R5 decoy address and bare data without strobe
        wr(10'h3F6, 8'h01);
        chk("R5 decoy", int'(rate_pins), 3);
        chk("R5 decoy upper", int'(dsr_upper), 6'b101101);
        host_addr = 10'h004; host_wdata = 8'h01;
        idle(2);
        chk("R5 no strobe", int'(rate_pins), 3);
        chk("R5 no strobe div", int'(clk_div_sel), 3);

        // R4 alias override both ways
        wr(10'h004, 8'h01);
        chk("R4 dsr then", int'(rate_pins), 1);
        chk("R6 div 300k", int'(clk_div_sel), 10);
        wr(10'h3F7, 8'h00);
        chk("R4 ccr overrides", int'(rate_pins), 0);
        chk("R6 div 500k", int'(clk_div_sel), 6);
        chk("R8 upper kept", int'(dsr_upper), 0);

        // mixed pattern, back-to-back and spaced writes
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (lfsr[1:0])
                2'd0: wr(10'h3F7, lfsr[15:8]);
                2'd1: wr(10'h004, lfsr[15:8]);
                2'd2: wr({lfsr[9:2]} ^ 10'h155, lfsr[15:8]);
                default: idle(int'(lfsr[3:2]) + 1);
            endcase
        end

        // R1 reset mid-run returns to defaults
        wr(10'h004, 8'hFF);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R1 re-reset pins", int'(rate_pins), 0);
        chk("R1 re-reset upper", int'(dsr_upper), 0);
        idle(2);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule